// File: doc/BRIEF.md
# Two-Line Write-Back Data Cache

This block is a small direct-mapped data cache placed between a processor load/store port and a memory port that moves one whole block per transfer. The processor side carries aligned 32-bit words. The memory side carries 8-byte blocks and uses a request/acknowledge handshake. With the default parameters the address is 8 bits wide and the cache holds two lines of 8 bytes each. Every line keeps a valid flag, a modified flag and a tag.

Stores follow a write-back, write-allocate policy. A store that misses first brings the whole block in from memory and then merges the word into it. A store that hits only updates the cache. When a miss lands on a modified line, the old block is written back at its own address before the new block is fetched. When a miss lands on a clean or empty line, the old contents are simply dropped.

Each access is reported exactly once on one of three status pulses: hit, clean miss or dirty miss. A miss to an empty line counts as a clean miss. The processor holds its request steady while `cpu_stall` is high. The access is finished in the cycle in which `cpu_done` is high.

Top module: `dm_wb_cache`

## Requirements
- R1: The address splits into tag = addr[7:4], line index = addr[3] and byte offset = addr[2:0]. Only word-aligned addresses are used (addr[1:0] = 0). addr[2] picks the word inside the line, and word 0 is bits [31:0] of the 64-bit memory block. Memory block addresses always have addr[2:0] = 0.
- R2: After reset every line is invalid. Before any request, the outputs `cpu_stall`, `mem_req` and the three status pulses are low. The first access to any line is reported as a clean miss and causes no memory write.
- R3: A load or store to a valid line whose tag matches raises `acc_hit` and `cpu_done` in the request cycle. It does not stall and makes no memory request. A load hit returns the addressed word on `cpu_rdata` in that same cycle.
- R4: A load miss to a clean or invalid line raises `acc_clean_miss` in the request cycle. It then issues one read (`mem_we` = 0) for the new block address. In the acknowledge cycle it completes with the addressed word of `mem_rdata`, and the line is left valid and clean.
- R5: A store miss reads the whole block from memory first and then merges the store word into it. The other word of the line keeps the value read from memory, and the line becomes modified.
- R6: A store hit writes the word into the line and marks the line modified, so that a later eviction of that line writes it back.
- R7: A miss onto a modified line raises `acc_dirty_miss`. It first writes the full old line to memory at {old tag, index, 000} with `mem_we` = 1, and only after that write is acknowledged does it issue the read for the new block.
- R8: At most one of `acc_hit`, `acc_clean_miss`, `acc_dirty_miss` is high in any cycle. Each access raises exactly one of them, for exactly one cycle.
- R9: Once `mem_req` is raised, `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.
- R10: Starting from reset, the accesses load 0, store 44, load 52, load 88, load 0, store 52, load 68, load 44 report, in order: clean, clean, clean, dirty, clean, clean, dirty, clean.
- R11: `cpu_stall` is high in every cycle of a pending request except the cycle in which `cpu_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 8 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while cpu_done |
| cpu_stall | output | 1 | Access pending, processor must wait |
| cpu_done | output | 1 | Access completes this cycle |
| acc_hit | output | 1 | Pulse: access hit |
| acc_clean_miss | output | 1 | Pulse: miss, victim clean or invalid |
| acc_dirty_miss | output | 1 | Pulse: miss, victim modified |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 8 | Block-aligned memory address |
| mem_wdata | output | 64 | Block written back |
| mem_rdata | input | 64 | Block read, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the transfer |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, two lines of 8 bytes, and 32-bit words. With only one index bit, any two addresses that share addr[3] but differ in addr[7:4] evict each other. This makes it easy to reach, within a few accesses, clean and dirty victims, a store miss merging into a fetched block, and a store hit that is later written back. The memory model answers each request after a fixed delay and checks every written-back block against a reference image held in the bench.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } ctrl_state_t;
endpackage

// File: rtl/cache_tag_array.sv
module cache_tag_array #(
  parameter int NUM_LINES = 2,
  parameter int TAG_W     = 4,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             mark_en
);
  logic [NUM_LINES-1:0] valid_vec;
  logic [NUM_LINES-1:0] dirty_vec;
  logic [TAG_W-1:0]     tag_vec [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic             v_q;
    logic             d_q;
    logic [TAG_W-1:0] t_q;
    wire              sel = (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
      end else if (fill_en && sel) begin
        v_q <= 1'b1;
        d_q <= fill_dirty;
        t_q <= fill_tag;
      end else if (mark_en && sel) begin
        d_q <= 1'b1;
      end
    end
    assign valid_vec[i] = v_q;
    assign dirty_vec[i] = d_q;
    assign tag_vec[i]   = t_q;
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_dirty = dirty_vec[rd_idx];
  assign rd_tag   = tag_vec[rd_idx];

  // R5/R4: a fill leaves the line valid with the requested modified state
  p_fill_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_vec[$past(wr_idx)] && (dirty_vec[$past(wr_idx)] == $past(fill_dirty))
                 && (tag_vec[$past(wr_idx)] == $past(fill_tag))));
  // R6: marking a line sets its modified flag
  p_mark_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !fill_en) |=> dirty_vec[$past(wr_idx)]);
endmodule

// File: rtl/cache_data_array.sv
module cache_data_array #(
  parameter int NUM_LINES = 2,
  parameter int LINE_W    = 64,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int WPL      = LINE_W / WORD_W,
  localparam int WSEL_W   = (WPL > 1) ? $clog2(WPL) : 1
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              line_wr_en,
  input  logic [LINE_W-1:0] line_wr_data,
  input  logic              word_wr_en,
  input  logic [WSEL_W-1:0] word_sel,
  input  logic [WORD_W-1:0] word_wr_data
);
  logic [LINE_W-1:0] line_vec [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [LINE_W-1:0] l_q;
    wire               sel = (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (line_wr_en && sel)
        l_q <= line_wr_data;
      else if (word_wr_en && sel)
        l_q[word_sel*WORD_W +: WORD_W] <= word_wr_data;
    end
    assign line_vec[i] = l_q;
  end

  assign rd_line = line_vec[rd_idx];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic lookup_hit,
  input  logic victim_dirty,
  input  logic mem_ack,
  output logic in_fill,
  output logic done,
  output logic ev_hit,
  output logic ev_clean,
  output logic ev_dirty,
  output logic mem_req,
  output logic mem_we,
  output logic fill_commit
);
  ctrl_state_t state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    done        = 1'b0;
    ev_hit      = 1'b0;
    ev_clean    = 1'b0;
    ev_dirty    = 1'b0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    fill_commit = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cpu_req) begin
        if (lookup_hit) begin
          ev_hit = 1'b1;
          done   = 1'b1;
        end else if (victim_dirty) begin
          ev_dirty = 1'b1;
          state_d  = ST_WBACK;
        end else begin
          ev_clean = 1'b1;
          state_d  = ST_FILL;
        end
      end
      ST_WBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          fill_commit = 1'b1;
          done        = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign in_fill = (state_q == ST_FILL);

  // R8: one outcome per cycle
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_hit, ev_clean, ev_dirty}));
  // R7: dirty miss starts with a write-back
  p_dirty_wback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dirty |=> (mem_req && mem_we));
  // R7: acknowledged write-back is followed by the block read
  p_wback_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
  // R4: clean miss goes straight to the read
  p_clean_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clean |=> (mem_req && !mem_we));
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W     = 8,
  parameter int LINE_BYTES = 8,
  parameter int NUM_LINES  = 2,
  parameter int WORD_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WB_W      = $clog2(WORD_W / 8),
  localparam int WPL       = LINE_W / WORD_W,
  localparam int WSEL_W    = (WPL > 1) ? $clog2(WPL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic              acc_hit,
  output logic              acc_clean_miss,
  output logic              acc_dirty_miss,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [WSEL_W-1:0] addr_wsel(input logic [ADDR_W-1:0] a);
    return a[WB_W +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] block_addr(input logic [TAG_W-1:0] t,
                                                   input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction
  function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] l,
                                                   input logic [WSEL_W-1:0] s,
                                                   input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = l;
    r[s*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  wire [TAG_W-1:0]  req_tag  = addr_tag(cpu_addr);
  wire [IDX_W-1:0]  req_idx  = addr_idx(cpu_addr);
  wire [WSEL_W-1:0] req_wsel = addr_wsel(cpu_addr);

  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [LINE_W-1:0] line_data;
  logic              lookup_hit, victim_dirty;
  logic              in_fill, done, fill_commit, ctrl_mem_we;
  logic              store_hit;
  logic [LINE_W-1:0] fill_line;

  assign lookup_hit   = line_valid && (line_tag == req_tag);
  assign victim_dirty = line_valid && line_dirty;

  cache_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .lookup_hit   (lookup_hit),
    .victim_dirty (victim_dirty),
    .mem_ack      (mem_ack),
    .in_fill      (in_fill),
    .done         (done),
    .ev_hit       (acc_hit),
    .ev_clean     (acc_clean_miss),
    .ev_dirty     (acc_dirty_miss),
    .mem_req      (mem_req),
    .mem_we       (ctrl_mem_we),
    .fill_commit  (fill_commit)
  );

  assign store_hit = acc_hit && cpu_we;
  assign fill_line = cpu_we ? merge_word(mem_rdata, req_wsel, cpu_wdata) : mem_rdata;

  cache_tag_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (req_idx),
    .rd_valid   (line_valid),
    .rd_dirty   (line_dirty),
    .rd_tag     (line_tag),
    .fill_en    (fill_commit),
    .wr_idx     (req_idx),
    .fill_tag   (req_tag),
    .fill_dirty (cpu_we),
    .mark_en    (store_hit)
  );

  cache_data_array #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
    .clk          (clk),
    .rd_idx       (req_idx),
    .rd_line      (line_data),
    .wr_idx       (req_idx),
    .line_wr_en   (fill_commit),
    .line_wr_data (fill_line),
    .word_wr_en   (store_hit),
    .word_sel     (req_wsel),
    .word_wr_data (cpu_wdata)
  );

  assign mem_we    = ctrl_mem_we;
  assign mem_addr  = in_fill ? block_addr(req_tag, req_idx) : block_addr(line_tag, req_idx);
  assign mem_wdata = line_data;
  assign cpu_done  = done;
  assign cpu_stall = cpu_req && !done;
  assign cpu_rdata = in_fill ? mem_rdata[req_wsel*WORD_W +: WORD_W]
                             : line_data[req_wsel*WORD_W +: WORD_W];

  // R1: processor addresses are word aligned, memory addresses block aligned
  p_cpu_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_addr[WB_W-1:0] == '0));
  p_mem_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));
  // R3: a hit neither stalls nor touches memory
  p_hit_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> (!cpu_stall && !mem_req));
  // R9: request held until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R11: stall and done never overlap
  p_stall_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_stall && cpu_done));
endmodule

// File: tb/dm_wb_cache_tb_top.sv
`timescale 1ns/1ps
module dm_wb_cache_tb_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall, cpu_done, acc_hit, acc_clean_miss, acc_dirty_miss;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
  logic [7:0]  held_addr, last_wr_addr;
  logic [63:0] memarr [32];
  logic [63:0] refmem [32];

  always #2 clk = ~clk;

  dm_wb_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
    .acc_hit(acc_hit), .acc_clean_miss(acc_clean_miss), .acc_dirty_miss(acc_dirty_miss),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: answers after LAT cycles, checks write-backs against the reference image
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end else if (mem_req) begin
      if (wait_cnt == 0) held_addr = mem_addr;
      else check(mem_addr == held_addr, "R9 address held", mem_addr, held_addr);
      wait_cnt++;
      if (wait_cnt >= LAT) begin
        mem_ack = 1'b1;
        check(mem_addr[2:0] == 3'b000, "R1 block aligned", mem_addr, {mem_addr[7:3], 3'b000});
        if (mem_we) begin
          check(mem_wdata == refmem[mem_addr[7:3]], "R7 write-back data",
                mem_wdata, refmem[mem_addr[7:3]]);
          memarr[mem_addr[7:3]] = mem_wdata;
          wr_cnt++;
          last_wr_addr = mem_addr;
        end else begin
          mem_rdata = memarr[mem_addr[7:3]];
          rd_cnt++;
        end
      end
    end
  end

  // outcome codes: 0 hit, 1 clean miss, 2 dirty miss
  task automatic do_access(input bit we, input logic [7:0] a, input logic [31:0] wd,
                           input int exp_o, input logic [7:0] exp_wb, input string req);
    int cyc = 0, nh = 0, nc = 0, nd = 0, obs;
    int rd0 = rd_cnt, wr0 = wr_cnt;
    bit fin = 1'b0, stall_ok = 1'b1;
    logic [31:0] got = '0, expw;
    expw = refmem[a[7:3]][a[2]*32 +: 32];
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!fin && cyc < 64) begin
      #1;
      nh += int'(acc_hit); nc += int'(acc_clean_miss); nd += int'(acc_dirty_miss);
      if (cpu_done) begin
        fin = 1'b1;
        got = cpu_rdata;
        if (cpu_stall) stall_ok = 1'b0;
      end else if (!cpu_stall) stall_ok = 1'b0;
      cyc++;
      @(negedge clk);
    end
    cpu_req = 1'b0;
    obs = (nd != 0) ? 2 : (nc != 0) ? 1 : (nh != 0) ? 0 : -1;
    check(fin, {req, " access completes"}, fin, 1);
    check(nh + nc + nd == 1, "R8 one status pulse", nh + nc + nd, 1);
    check(obs == exp_o, {req, " outcome"}, obs, exp_o);
    check(stall_ok, "R11 stall until done", stall_ok, 1);
    if (!we) check(got == expw, {req, " R1 load word"}, got, expw);
    if (exp_o == 0) begin
      check(cyc == 1, "R3 hit in one cycle", cyc, 1);
      check(rd_cnt == rd0 && wr_cnt == wr0, "R3 no memory traffic", rd_cnt - rd0 + wr_cnt - wr0, 0);
    end else begin
      check(rd_cnt == rd0 + 1, {req, " one block read"}, rd_cnt - rd0, 1);
      check(wr_cnt == wr0 + (exp_o == 2 ? 1 : 0), {req, " write-back count"},
            wr_cnt - wr0, exp_o == 2 ? 1 : 0);
      if (exp_o == 2) check(last_wr_addr == exp_wb, "R7 write-back address", last_wr_addr, exp_wb);
    end
    if (we) refmem[a[7:3]][a[2]*32 +: 32] = wd;
  endtask

  task automatic t_reset;
    #1;
    check(!cpu_stall && !mem_req, "R2 idle after reset", {cpu_stall, mem_req}, 0);
    check({acc_hit, acc_clean_miss, acc_dirty_miss} == 3'b000, "R2 no status after reset",
          {acc_hit, acc_clean_miss, acc_dirty_miss}, 0);
  endtask

  task automatic t_ordered_sequence;
    do_access(0, 8'd0,  '0,            1, 8'h00, "R10 R2 load 0");
    do_access(1, 8'd44, 32'h1111_2222, 1, 8'h00, "R10 R5 store 44");
    do_access(0, 8'd52, '0,            1, 8'h00, "R10 R4 load 52");
    do_access(0, 8'd88, '0,            2, 8'h28, "R10 R7 load 88");
    do_access(0, 8'd0,  '0,            1, 8'h00, "R10 load 0");
    do_access(1, 8'd52, 32'h3333_4444, 1, 8'h00, "R10 store 52");
    do_access(0, 8'd68, '0,            2, 8'h30, "R10 R7 load 68");
    do_access(0, 8'd44, '0,            1, 8'h00, "R10 load 44");
  endtask

  task automatic t_hits;
    do_access(0, 8'd44, '0, 0, 8'h00, "R3 load hit word1");
    do_access(0, 8'd40, '0, 0, 8'h00, "R3 load hit word0");
  endtask

  task automatic t_store_merge;
    do_access(1, 8'h7C, 32'hDEAD_BEEF, 1, 8'h00, "R5 store miss");
    do_access(0, 8'h78, '0, 0, 8'h00, "R5 fetched word kept");
    do_access(0, 8'h7C, '0, 0, 8'h00, "R5 merged word");
  endtask

  task automatic t_store_hit;
    do_access(1, 8'h40, 32'hCAFE_F00D, 0, 8'h00, "R6 store hit");
    do_access(0, 8'h00, '0, 2, 8'h40, "R6 evict modified line");
    do_access(0, 8'h40, '0, 1, 8'h00, "R6 reload stored word");
    do_access(0, 8'h08, '0, 2, 8'h78, "R7 evict store-miss line");
  endtask

  initial begin
    for (int l = 0; l < 32; l++) begin
      for (int b = 0; b < 8; b++) memarr[l][b*8 +: 8] = 8'(l * 8 + b) ^ 8'hA5;
      refmem[l] = memarr[l];
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ordered_sequence();
    t_hits();
    t_store_merge();
    t_store_hit();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule